// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block is the digital controller of a 12-bit successive-approximation converter and runs on the converter clock. A 3-bit source-select input picks what launches a conversion. It can be one of three hardware start lines, the AND of all three, a software start pulse, or a free-running continuous mode. The selected hardware line forms one internal start strobe, and a conversion begins on the falling edge of that strobe. The sequencer then walks through its phases. It raises the power enable when the analog front end is off, holds the track/hold in track for the acquisition window, and switches it to hold. It then runs the bit-trial register for twelve clocks against a single comparator input, and spends one last clock copying the finished word into the result register.

The controller is a five-state machine: `PH_IDLE`, `PH_PWRUP` (front end powering up, track/hold tracking), `PH_ACQ` (acquisition, tracking), `PH_SETTLE` (hold, settling) and `PH_CONV` (hold, bit trials plus transfer). The transitions are as follows:
- `PH_IDLE` goes to `PH_PWRUP` on a start while powered down.
- `PH_IDLE` goes to `PH_ACQ` on a start while powered.
- `PH_PWRUP` goes to `PH_ACQ` when the power-up count expires.
- `PH_ACQ` goes to `PH_SETTLE` in single mode, or straight to `PH_CONV` in continuous mode.
- `PH_SETTLE` goes to `PH_CONV`.
- `PH_CONV` goes to `PH_ACQ` when continuous mode is still selected, and otherwise to `PH_IDLE`.

The auto-shutdown input decides whether the front end powers down after each result. This is why a conversion takes 27 clocks from power-down and 17 clocks when already powered.

Top module: `adc_conv_sequencer`

## Requirements
- R1: The source-select codes are as follows. Codes 3'b000, 3'b001 and 3'b010 select hardware start line 0, 1 and 2. Code 3'b100 selects the AND of all three lines, so the strobe falls when any line falls. Code 3'b110 selects continuous mode and 3'b111 selects software start. Codes 3'b011 and 3'b101 start nothing.
- R2: In a hardware mode, a conversion is accepted on the first clock edge that samples the selected strobe low when the previous edge sampled it high.
- R3: With code 3'b111, a one-clock `sw_start` pulse launches one conversion. `busy` is high from the next cycle until the result is ready, and it falls only in the cycle where `done` is high.
- R4: From power-down, a start accepted on edge k updates `result` and raises `done` on edge k+27. The phases are 10 clocks of power-up, 3 of acquisition, 1 of settling and 13 of conversion.
- R5: When powered, a start accepted on edge k updates `result` and raises `done` on edge k+17.
- R6: After reset the front end is powered down. At the end of each single conversion, `pwr_en` stays low while idle if `auto_sd`=1, and stays high if `auto_sd`=0. `pwr_en` is high whenever `busy` is high.
- R7: Holding code 3'b110 while idle starts continuous conversion. A new result then arrives every 16 clocks (3 acquisition plus 13 conversion). The first result comes 24 clocks after entry from power-down (8 power-up clocks) and 16 clocks after entry when powered. Selecting any other code ends the run after the conversion in progress.
- R8: `track` is high during power-up and acquisition and low otherwise. In a powered single conversion it is high for exactly 3 cycles after the start edge, and for 13 cycles from power-down.
- R9: The trial word on `dac_code` starts at 12'h800 and resolves one bit per clock from MSB to LSB. `comp_in`=1 keeps the bit under trial. The transferred result therefore equals the binary-search answer of the comparator.
- R10: A start event while `busy` is high is ignored and does not change that conversion's timing. A software start during continuous mode is ignored.
- R11: `done` is a one-cycle pulse for each new result. `result` keeps its previous value until the next transfer.
- R12: During reset, `busy`, `done`, `track` and `pwr_en` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Start-source / mode select code |
| hw_start | input | 3 | Three hardware start lines (active falling edge) |
| sw_start | input | 1 | Software start pulse (write of 1 to the start/busy bit) |
| auto_sd | input | 1 | Power down the front end after each conversion |
| comp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | RES_W | Current trial word to the DAC |
| track | output | 1 | Track/hold control: 1 track, 0 hold |
| pwr_en | output | 1 | Analog front-end power enable |
| busy | output | 1 | Start/busy status |
| done | output | 1 | One-cycle pulse with each new result |
| result | output | RES_W | Last completed conversion word |

## Verification
A table of single conversions walks every hardware source code and the software code. It mixes auto-shutdown settings so that powered and powered-down starts alternate, which separates the 17-clock path from the 27-clock path and the 3-cycle tracking window from the 13-cycle one. The comparator is modelled from a target code, and the targets include all-zeros, all-ones, mid-scale and neighbours of mid-scale, so a dropped or misordered bit trial gives a wrong word. Directed runs cover continuous entry from both power states, the 16-clock period, leaving continuous mode, a second strobe fall during a conversion, and a non-starting code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PWRUP,
        PH_ACQ,
        PH_SETTLE,
        PH_CONV
    } phase_t;

    localparam logic [2:0] SRC_HW0  = 3'b000;
    localparam logic [2:0] SRC_HW1  = 3'b001;
    localparam logic [2:0] SRC_HW2  = 3'b010;
    localparam logic [2:0] SRC_ANY  = 3'b100;
    localparam logic [2:0] SRC_CONT = 3'b110;
    localparam logic [2:0] SRC_SW   = 3'b111;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_start_sel.sv
module adc_start_sel
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel,
    input  logic [2:0] hw_start,
    input  logic       sw_start,
    input  logic       idle,
    output logic       single_go,
    output logic       cont_go,
    output logic       cont_sel
);

    logic strobe;
    logic strobe_q;
    logic hw_mode;
    logic hw_fall;

    // Selected hardware strobe; codes without a line hold it high (no edge)
    always_comb begin
        hw_mode = 1'b1;
        case (src_sel)
            SRC_HW0: strobe = hw_start[0];
            SRC_HW1: strobe = hw_start[1];
            SRC_HW2: strobe = hw_start[2];
            SRC_ANY: strobe = &hw_start;
            default: begin
                strobe  = 1'b1;
                hw_mode = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign hw_fall   = hw_mode & strobe_q & ~strobe;
    assign cont_sel  = (src_sel == SRC_CONT);
    assign single_go = idle & (hw_fall | (sw_start & (src_sel == SRC_SW)));
    assign cont_go   = idle & cont_sel;

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int PWRUP_CYC      = 10,
    parameter int CONT_PWRUP_CYC = 8,
    parameter int ACQ_CYC        = 3,
    parameter int SETTLE_CYC     = 1,
    parameter int CONV_CYC       = 13,
    parameter int CNT_W          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single_go,
    input  logic             cont_go,
    input  logic             cont_sel,
    input  logic             auto_sd,
    output logic             idle,
    output logic             busy,
    output logic             track,
    output logic             pwr_en,
    output logic             conv_load,
    output logic             trial_en,
    output logic             conv_xfer,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cont_q, cont_d;
    logic             powered_q, powered_d;
    logic             done_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // Next-state logic
    always_comb begin
        phase_d   = phase_q;
        cnt_d     = cnt_zero ? cnt_q : cnt_q - 1'b1;
        cont_d    = cont_q;
        powered_d = powered_q;
        done_d    = 1'b0;
        conv_load = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (single_go) begin
                    cont_d = 1'b0;
                    if (powered_q) begin
                        phase_d = PH_ACQ;
                        cnt_d   = CNT_W'(ACQ_CYC - 1);
                    end else begin
                        phase_d = PH_PWRUP;
                        cnt_d   = CNT_W'(PWRUP_CYC - 1);
                    end
                end else if (cont_go) begin
                    cont_d = 1'b1;
                    if (powered_q) begin
                        phase_d = PH_ACQ;
                        cnt_d   = CNT_W'(ACQ_CYC - 1);
                    end else begin
                        phase_d = PH_PWRUP;
                        cnt_d   = CNT_W'(CONT_PWRUP_CYC - 1);
                    end
                end
            end
            PH_PWRUP: begin
                if (cnt_zero) begin
                    phase_d   = PH_ACQ;
                    cnt_d     = CNT_W'(ACQ_CYC - 1);
                    powered_d = 1'b1;
                end
            end
            PH_ACQ: begin
                if (cnt_zero) begin
                    if (cont_q) begin
                        phase_d   = PH_CONV;
                        cnt_d     = CNT_W'(CONV_CYC - 1);
                        conv_load = 1'b1;
                    end else begin
                        phase_d = PH_SETTLE;
                        cnt_d   = CNT_W'(SETTLE_CYC - 1);
                    end
                end
            end
            PH_SETTLE: begin
                if (cnt_zero) begin
                    phase_d   = PH_CONV;
                    cnt_d     = CNT_W'(CONV_CYC - 1);
                    conv_load = 1'b1;
                end
            end
            PH_CONV: begin
                if (cnt_zero) begin
                    done_d = 1'b1;
                    if (cont_q && cont_sel) begin
                        phase_d   = PH_ACQ;
                        cnt_d     = CNT_W'(ACQ_CYC - 1);
                        powered_d = 1'b1;
                    end else begin
                        phase_d   = PH_IDLE;
                        cont_d    = 1'b0;
                        powered_d = ~auto_sd;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            cont_q    <= 1'b0;
            powered_q <= 1'b0;
            done      <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            cnt_q     <= cnt_d;
            cont_q    <= cont_d;
            powered_q <= powered_d;
            done      <= done_d;
        end
    end

    // Outputs
    always_comb begin
        idle      = (phase_q == PH_IDLE);
        busy      = ~idle;
        track     = (phase_q == PH_PWRUP) || (phase_q == PH_ACQ);
        pwr_en    = powered_q | busy;
        trial_en  = (phase_q == PH_CONV) && !cnt_zero;
        conv_xfer = (phase_q == PH_CONV) && cnt_zero;
        cnt       = cnt_q;
    end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_W = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             trial_en,
    input  logic             xfer,
    input  logic [CNT_W-1:0] cnt,
    input  logic             comp_in,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);

    // cnt counts RES_W..1 during the trials; bit under trial is cnt-1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (load) begin
            trial <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (trial_en) begin
            for (int i = 0; i < RES_W; i++) begin
                if (i + 1 == int'(cnt))      trial[i] <= comp_in;
                else if (i + 2 == int'(cnt)) trial[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    result <= '0;
        else if (xfer) result <= trial;
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int RES_W          = 12,
    parameter int PWRUP_CYC      = 10,
    parameter int CONT_PWRUP_CYC = 8,
    parameter int ACQ_CYC        = 3,
    parameter int SETTLE_CYC     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       src_sel,
    input  logic [2:0]       hw_start,
    input  logic             sw_start,
    input  logic             auto_sd,
    input  logic             comp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             track,
    output logic             pwr_en,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);

    localparam int CONV_CYC = RES_W + 1;
    localparam int MAX_CYC  = max2(max2(PWRUP_CYC, CONT_PWRUP_CYC),
                                   max2(max2(ACQ_CYC, SETTLE_CYC), CONV_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             idle;
    logic             single_go;
    logic             cont_go;
    logic             cont_sel;
    logic             conv_load;
    logic             trial_en;
    logic             conv_xfer;
    logic [CNT_W-1:0] cnt;

    adc_start_sel u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .hw_start  (hw_start),
        .sw_start  (sw_start),
        .idle      (idle),
        .single_go (single_go),
        .cont_go   (cont_go),
        .cont_sel  (cont_sel)
    );

    adc_phase_fsm #(
        .PWRUP_CYC      (PWRUP_CYC),
        .CONT_PWRUP_CYC (CONT_PWRUP_CYC),
        .ACQ_CYC        (ACQ_CYC),
        .SETTLE_CYC     (SETTLE_CYC),
        .CONV_CYC       (CONV_CYC),
        .CNT_W          (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .single_go (single_go),
        .cont_go   (cont_go),
        .cont_sel  (cont_sel),
        .auto_sd   (auto_sd),
        .idle      (idle),
        .busy      (busy),
        .track     (track),
        .pwr_en    (pwr_en),
        .conv_load (conv_load),
        .trial_en  (trial_en),
        .conv_xfer (conv_xfer),
        .cnt       (cnt),
        .done      (done)
    );

    adc_sar_reg #(
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_load),
        .trial_en (trial_en),
        .xfer     (conv_xfer),
        .cnt      (cnt),
        .comp_in  (comp_in),
        .trial    (dac_code),
        .result   (result)
    );

endmodule

// File: rtl/adc_conv_sequencer_chk.sv
module adc_conv_sequencer_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             track,
    input logic             pwr_en,
    input logic [RES_W-1:0] result
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R11

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3

    AST_POWER_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pwr_en); // R6

    AST_NO_TRACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !track); // R8

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(track) |-> busy); // R8

endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(.RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .track  (track),
    .pwr_en (pwr_en),
    .result (result)
);

// File: tb/adc_conv_sequencer_test.sv
`timescale 1ns/1ps
module adc_conv_sequencer_test;

    localparam int RES_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       src_sel = 3'b011;
    logic [2:0]       hw_start = 3'b111;
    logic             sw_start = 1'b0;
    logic             auto_sd = 1'b0;
    logic [RES_W-1:0] vin = '0;
    logic             comp_in;
    logic [RES_W-1:0] dac_code;
    logic             track, pwr_en, busy, done;
    logic [RES_W-1:0] result;

    int n_chk = 0;
    int n_err = 0;
    bit pwr_m = 1'b0;

    always #4 clk = ~clk;

    assign comp_in = (vin >= dac_code);

    adc_conv_sequencer uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .hw_start(hw_start),
        .sw_start(sw_start), .auto_sd(auto_sd), .comp_in(comp_in),
        .dac_code(dac_code), .track(track), .pwr_en(pwr_en), .busy(busy),
        .done(done), .result(result)
    );

    // {src_sel, target code, auto_sd}
    localparam logic [15:0] VEC [8] = '{
        {3'b000, 12'h5A3, 1'b0},
        {3'b001, 12'hFFF, 1'b0},
        {3'b010, 12'h000, 1'b1},
        {3'b111, 12'h801, 1'b0},
        {3'b100, 12'h7FF, 1'b0},
        {3'b111, 12'h001, 1'b1},
        {3'b100, 12'hABC, 1'b1},
        {3'b000, 12'h800, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    // Called right after inputs for a start were driven at a negedge.
    task automatic measure(input int trk_len, output int lat, output int terr);
        lat = 0;
        terr = 0;
        @(posedge clk); #1;
        while (!done && lat < 80) begin
            if (trk_len > 0 && (track != (lat < trk_len))) terr++;
            if (!busy) terr++;
            @(posedge clk); #1;
            lat++;
        end
    endtask

    task automatic next_done(output int lat);
        lat = 0;
        do begin
            @(posedge clk); #1;
            lat++;
        end while (!done && lat < 80);
    endtask

    task automatic quiet(input int cycles, output int dones, output int busies);
        dones = 0;
        busies = 0;
        repeat (cycles) begin
            @(posedge clk); #1;
            if (done) dones++;
            if (busy) busies++;
        end
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int lat, terr, dn, bz, exp_lat, idx;
        logic [2:0] s;

        // R12: reset values
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !done && !track && !pwr_en, "R12 flags", {busy, done, track, pwr_en}, 0);
        check(result == '0, "R12 result", int'(result), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R8 R9
        for (int v = 0; v < 8; v++) begin
            s = VEC[v][15:13];
            @(negedge clk);
            src_sel = s;
            vin = VEC[v][12:1];
            auto_sd = VEC[v][0];
            repeat (2) @(negedge clk);
            exp_lat = pwr_m ? 17 : 27;
            if (s == 3'b111) sw_start = 1'b1;
            else begin
                idx = (s == 3'b100) ? 1 : int'(s);
                hw_start[idx] = 1'b0;
            end
            measure(pwr_m ? 3 : 13, lat, terr);
            sw_start = 1'b0;
            check(lat == exp_lat, pwr_m ? "R5 latency" : "R4 latency", lat, exp_lat);
            check(result == vin, "R9 result", int'(result), int'(vin));
            check(terr == 0, "R8 track/R3 busy window", terr, 0);
            pwr_m = ~auto_sd;
            @(negedge clk);
            hw_start = 3'b111;
            check(pwr_en == pwr_m, "R6 power after conversion", pwr_en, pwr_m);
        end

        // R1: code 3'b011 starts nothing
        @(negedge clk) src_sel = 3'b011;
        repeat (2) @(negedge clk);
        hw_start = 3'b000;
        quiet(30, dn, bz);
        check(dn == 0 && bz == 0, "R1 no-start code", dn + bz, 0);
        @(negedge clk) hw_start = 3'b111;

        // R7 continuous, powered entry (pwr_m is 1 here)
        @(negedge clk);
        auto_sd = 1'b1;
        vin = 12'h3C5;
        src_sel = 3'b110;
        measure(0, lat, terr);
        check(lat == (pwr_m ? 16 : 24), "R7 first result", lat, pwr_m ? 16 : 24);
        check(result == 12'h3C5, "R7 R9 result", int'(result), 12'h3C5);
        vin = 12'h0F0;
        next_done(lat);
        check(lat == 16, "R7 period", lat, 16);
        check(result == 12'h0F0, "R7 tracking input", int'(result), 12'h0F0);
        // R10: software start during continuous mode ignored
        repeat (5) @(posedge clk);
        #1 sw_start = 1'b1;
        @(posedge clk); #1 sw_start = 1'b0;
        next_done(lat);
        check(lat == 10, "R10 continuous period kept", lat, 10);
        src_sel = 3'b111;
        next_done(lat);
        check(lat == 16 && !busy, "R7 exit after current conversion", lat, 16);
        quiet(40, dn, bz);
        check(dn == 0 && bz == 0, "R7 stopped", dn + bz, 0);
        check(pwr_en == 1'b0, "R6 powered down after continuous", pwr_en, 0);

        // R7 continuous entry from power-down
        @(negedge clk);
        vin = 12'hE11;
        src_sel = 3'b110;
        measure(0, lat, terr);
        check(lat == 24, "R7 first result from power-down", lat, 24);
        check(result == 12'hE11, "R7 R9 result", int'(result), 12'hE11);
        auto_sd = 1'b0;
        src_sel = 3'b000;
        next_done(lat);
        check(lat == 16 && !busy, "R7 exit", lat, 16);
        pwr_m = 1'b1;

        // R10: second strobe fall during a conversion is ignored
        repeat (3) @(negedge clk);
        vin = 12'h456;
        hw_start[0] = 1'b0;
        @(posedge clk); #1;
        lat = 0;
        while (!done && lat < 80) begin
            @(posedge clk); #1;
            lat++;
            if (lat == 4) hw_start[0] = 1'b1;
            if (lat == 6) hw_start[0] = 1'b0;
        end
        check(lat == 17, "R10 timing unchanged", lat, 17);
        check(result == 12'h456, "R10 result", int'(result), 12'h456);
        quiet(40, dn, bz);
        check(dn == 0 && bz == 0, "R10 no extra conversion", dn + bz, 0);
        // R11: result held while idle
        check(result == 12'h456, "R11 result held", int'(result), 12'h456);

        finish_run();
    end

endmodule